// File: doc/BRIEF.md
# Table-Driven Single-Tape Turing Machine Engine

This block runs a deterministic single-tape Turing machine. The tape is a bounded array of 256 cells of 4 bits each. Symbol value 0 means blank. The program is a rule table with one entry for every pair of current state and symbol read, so it holds 16 x 16 = 256 entries. Each entry gives the next state, the symbol to write and a direction bit.

The host works in three stages while the engine is idle:
1. It fills the rule table through the rule port.
2. It writes the input string into the leftmost tape cells through the tape port.
3. It chooses a start state, an accept state, a reject state and a step limit, then pulses `start`.

The engine puts the head on cell 0 and performs one transition per clock. When the run ends it holds `done` high with exactly one outcome flag: accepted, rejected, timed out, or ran off the right end of the tape. The tape can be read back at any time through a separate read address.

Top module: `tm_engine`

## Requirements
- R1: After reset, `busy`, `done` and all four outcome flags are 0, `head_pos` is 0, and every tape cell reads back as 0 (blank).
- R2: A `start` pulse while the engine is not busy sets `busy` on the next clock. It places the head on cell 0 and loads `start_state` as the current state. It also latches the accept state, the reject state and the step limit.
- R3: A transition looks up the rule at address {state[3:0], symbol[3:0]}. The rule is formatted as data[8:5] next state, data[4:1] symbol to write, and data[0] direction (1 = right, 0 = left). The transition writes the rule's symbol into the cell under the head, moves the head one cell and adopts the next state.
- R4: When the current state equals the latched accept state, the run ends with `done`=1 and `accepted`=1. When it equals the latched reject state, the run ends with `done`=1 and `rejected`=1. In both cases no further transition happens. The accept check takes priority over the reject check and the limit check.
- R5: A run that ends by accept, reject or timeout after k transitions keeps `busy` high for exactly k+1 clocks. A run that starts in a halting state therefore keeps `busy` high for 1 clock and leaves the tape unchanged.
- R6: After exactly `step_limit` transitions without halting, the run ends with `timed_out`=1. A `step_limit` of 0 times out with no transition.
- R7: A left move from cell 0 leaves the head on cell 0.
- R8: A right move from cell 255 still performs the write and the state update. It leaves the head on 255 and ends the run with `overflow`=1, so `busy` lasts exactly k clocks for k transitions.
- R9: The outcome flags are 0 whenever `done` is 0. While `done` is 1, exactly one of them is 1.
- R10: `done` and the outcome stay unchanged until the next `start`.
- R11: While `busy` is high, writes on the rule port and the tape port are ignored, and so is `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rule_we | input | 1 | Rule table write strobe |
| rule_addr | input | 8 | Rule index {state, symbol} |
| rule_data | input | 9 | {next state, write symbol, right} |
| tape_we | input | 1 | Host tape write strobe |
| tape_waddr | input | 8 | Host tape write cell |
| tape_wdata | input | 4 | Host tape write symbol |
| tape_raddr | input | 8 | Tape read-back cell |
| tape_rdata | output | 4 | Symbol at `tape_raddr` |
| start_state | input | 4 | Initial state for the run |
| accept_state | input | 4 | Halting state meaning accept |
| reject_state | input | 4 | Halting state meaning reject |
| step_limit | input | 16 | Maximum transitions before timeout |
| start | input | 1 | Launch a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; outcome valid |
| accepted | output | 1 | Ended in accept state |
| rejected | output | 1 | Ended in reject state |
| timed_out | output | 1 | Step limit reached |
| overflow | output | 1 | Right move off the last cell |
| head_pos | output | 8 | Current head cell |

## Verification
The assertions assume that reset is held for at least one clock before any activity. They also assume that the head-movement property only applies between two consecutive busy cycles, because a new start returns the head to cell 0. The stimulus drives `start` only as single-cycle pulses and reconfigures only while idle, apart from one deliberate test of writes and a start issued during a run. All programs used either reach a halting state, loop under a step limit, or run into the right edge. No run therefore depends on table entries that were never written.

// File: rtl/tm_pkg.sv
package tm_pkg;
    localparam int SYM_W    = 4;
    localparam int STATE_W  = 4;
    localparam int ADDR_W   = 8;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int IDX_W    = STATE_W + SYM_W;
    localparam int ENTRIES  = 1 << IDX_W;
    localparam int RULE_W   = STATE_W + SYM_W + 1;

    typedef logic [SYM_W-1:0]   sym_t;
    typedef logic [STATE_W-1:0] state_t;
    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef struct packed {
        state_t nxt;
        sym_t   wr;
        logic   right;
    } rule_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        RES_ACC = 2'd0,
        RES_REJ = 2'd1,
        RES_TMO = 2'd2,
        RES_OVF = 2'd3
    } result_t;

    localparam sym_t BLANK = '0;

    function automatic idx_t rule_index(state_t st, sym_t sy);
        return {st, sy};
    endfunction
endpackage

// File: rtl/tm_rule_table.sv
module tm_rule_table
    import tm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  waddr,
    input  rule_t wdata,
    input  idx_t  raddr,
    output rule_t rdata
);
    rule_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tm_tape.sv
module tm_tape
    import tm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  host_we,
    input  addr_t host_waddr,
    input  sym_t  host_wdata,
    input  addr_t host_raddr,
    output sym_t  host_rdata,
    input  logic  eng_we,
    input  addr_t eng_addr,
    input  sym_t  eng_wdata,
    output sym_t  eng_rdata
);
    sym_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= BLANK;
        end else if (eng_we) begin
            cells[eng_addr] <= eng_wdata;
        end else if (host_we) begin
            cells[host_waddr] <= host_wdata;
        end
    end

    assign host_rdata = cells[host_raddr];
    assign eng_rdata  = cells[eng_addr];
endmodule

// File: rtl/tm_sequencer.sv
module tm_sequencer
    import tm_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  state_t             start_state,
    input  state_t             accept_state,
    input  state_t             reject_state,
    input  logic [LIMIT_W-1:0] step_limit,
    input  rule_t              rule,
    input  sym_t               cur_sym,
    output idx_t               lookup_idx,
    output logic               tape_we,
    output addr_t              tape_addr,
    output sym_t               tape_wdata,
    output logic               busy,
    output logic               done,
    output result_t            result,
    output addr_t              head
);
    localparam addr_t LAST_CELL = addr_t'(DEPTH - 1);

    phase_t             phase_q;
    state_t             cur_q;
    state_t             acc_q;
    state_t             rej_q;
    logic [LIMIT_W-1:0] lim_q;
    logic [LIMIT_W-1:0] steps_q;
    addr_t              head_q;
    result_t            res_q;

    logic hit_acc, hit_rej, hit_lim, do_step, launch;

    always_comb begin
        hit_acc = (cur_q == acc_q);
        hit_rej = (cur_q == rej_q);
        hit_lim = (steps_q == lim_q);
        do_step = (phase_q == PH_RUN) && !hit_acc && !hit_rej && !hit_lim;
        launch  = (phase_q != PH_RUN) && start;
    end

    assign lookup_idx = rule_index(cur_q, cur_sym);
    assign tape_we    = do_step;
    assign tape_addr  = head_q;
    assign tape_wdata = rule.wr;
    assign busy       = (phase_q == PH_RUN);
    assign done       = (phase_q == PH_DONE);
    assign result     = res_q;
    assign head       = head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cur_q   <= '0;
            acc_q   <= '0;
            rej_q   <= '0;
            lim_q   <= '0;
            steps_q <= '0;
            head_q  <= '0;
            res_q   <= RES_ACC;
        end else if (launch) begin
            phase_q <= PH_RUN;
            cur_q   <= start_state;
            acc_q   <= accept_state;
            rej_q   <= reject_state;
            lim_q   <= step_limit;
            steps_q <= '0;
            head_q  <= '0;
        end else if (phase_q == PH_RUN) begin
            if (hit_acc) begin
                phase_q <= PH_DONE;
                res_q   <= RES_ACC;
            end else if (hit_rej) begin
                phase_q <= PH_DONE;
                res_q   <= RES_REJ;
            end else if (hit_lim) begin
                phase_q <= PH_DONE;
                res_q   <= RES_TMO;
            end else begin
                cur_q   <= rule.nxt;
                steps_q <= steps_q + 1'b1;
                if (rule.right) begin
                    if (head_q == LAST_CELL) begin
                        phase_q <= PH_DONE;
                        res_q   <= RES_OVF;
                    end else begin
                        head_q <= head_q + 1'b1;
                    end
                end else if (head_q != '0) begin
                    head_q <= head_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tm_engine.sv
module tm_engine
    import tm_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rule_we,
    input  logic [IDX_W-1:0]   rule_addr,
    input  logic [RULE_W-1:0]  rule_data,
    input  logic               tape_we,
    input  logic [ADDR_W-1:0]  tape_waddr,
    input  logic [SYM_W-1:0]   tape_wdata,
    input  logic [ADDR_W-1:0]  tape_raddr,
    output logic [SYM_W-1:0]   tape_rdata,
    input  logic [STATE_W-1:0] start_state,
    input  logic [STATE_W-1:0] accept_state,
    input  logic [STATE_W-1:0] reject_state,
    input  logic [LIMIT_W-1:0] step_limit,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               accepted,
    output logic               rejected,
    output logic               timed_out,
    output logic               overflow,
    output logic [ADDR_W-1:0]  head_pos
);
    rule_t   cur_rule;
    idx_t    lookup_idx;
    sym_t    cur_sym;
    logic    eng_we;
    addr_t   eng_addr;
    sym_t    eng_wdata;
    result_t result;
    logic    busy_i, done_i;

    tm_rule_table u_rules (
        .clk   (clk),
        .rst   (rst),
        .we    (rule_we && !busy_i),
        .waddr (rule_addr),
        .wdata (rule_t'(rule_data)),
        .raddr (lookup_idx),
        .rdata (cur_rule)
    );

    tm_tape u_tape (
        .clk        (clk),
        .rst        (rst),
        .host_we    (tape_we && !busy_i),
        .host_waddr (tape_waddr),
        .host_wdata (tape_wdata),
        .host_raddr (tape_raddr),
        .host_rdata (tape_rdata),
        .eng_we     (eng_we),
        .eng_addr   (eng_addr),
        .eng_wdata  (eng_wdata),
        .eng_rdata  (cur_sym)
    );

    tm_sequencer #(.LIMIT_W(LIMIT_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_state  (start_state),
        .accept_state (accept_state),
        .reject_state (reject_state),
        .step_limit   (step_limit),
        .rule         (cur_rule),
        .cur_sym      (cur_sym),
        .lookup_idx   (lookup_idx),
        .tape_we      (eng_we),
        .tape_addr    (eng_addr),
        .tape_wdata   (eng_wdata),
        .busy         (busy_i),
        .done         (done_i),
        .result       (result),
        .head         (head_pos)
    );

    assign busy      = busy_i;
    assign done      = done_i;
    assign accepted  = done_i && (result == RES_ACC);
    assign rejected  = done_i && (result == RES_REJ);
    assign timed_out = done_i && (result == RES_TMO);
    assign overflow  = done_i && (result == RES_OVF);
endmodule

// File: rtl/tm_engine_chk.sv
module tm_engine_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              accepted,
    input logic              rejected,
    input logic              timed_out,
    input logic              overflow,
    input logic [ADDR_W-1:0] head_pos
);
    // R9
    flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> !(accepted || rejected || timed_out || overflow));

    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones({accepted, rejected, timed_out, overflow}) == 1);

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && head_pos == '0));

    // R3
    head_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |->
            ((ADDR_W'(head_pos - $past(head_pos)) == ADDR_W'(1)) ||
             (ADDR_W'($past(head_pos) - head_pos) == ADDR_W'(1)) ||
             (head_pos == $past(head_pos))));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
endmodule

bind tm_engine tm_engine_chk #(.ADDR_W(tm_pkg::ADDR_W)) u_tm_engine_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .accepted  (accepted),
    .rejected  (rejected),
    .timed_out (timed_out),
    .overflow  (overflow),
    .head_pos  (head_pos)
);

// File: tb/test_tm_engine.sv
module test_tm_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rule_we = 1'b0;
    logic [7:0]  rule_addr = '0;
    logic [8:0]  rule_data = '0;
    logic        tape_we = 1'b0;
    logic [7:0]  tape_waddr = '0;
    logic [3:0]  tape_wdata = '0;
    logic [7:0]  tape_raddr = '0;
    logic [3:0]  tape_rdata;
    logic [3:0]  start_state = '0;
    logic [3:0]  accept_state = 4'd14;
    logic [3:0]  reject_state = 4'd15;
    logic [15:0] step_limit = '0;
    logic        start = 1'b0;
    logic        busy, done, accepted, rejected, timed_out, overflow;
    logic [7:0]  head_pos;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    tm_engine i_tm_engine (
        .clk(clk), .rst(rst),
        .rule_we(rule_we), .rule_addr(rule_addr), .rule_data(rule_data),
        .tape_we(tape_we), .tape_waddr(tape_waddr), .tape_wdata(tape_wdata),
        .tape_raddr(tape_raddr), .tape_rdata(tape_rdata),
        .start_state(start_state), .accept_state(accept_state),
        .reject_state(reject_state), .step_limit(step_limit),
        .start(start), .busy(busy), .done(done), .accepted(accepted),
        .rejected(rejected), .timed_out(timed_out), .overflow(overflow),
        .head_pos(head_pos)
    );

    // outcome code: 0 accept, 1 reject, 2 timeout, 3 overflow
    // fields: {input 32 (cell0 = low nibble), start 4, limit 16, code 2,
    //          head 8, busy cycles 16, probe cell 8, probe symbol 4}
    localparam int NV = 12;
    localparam logic [89:0] VEC [NV] = '{
        {32'h00000000, 4'd0,  16'd100,  2'd0, 8'd0,   16'd2,   8'd0,   4'd3},
        {32'h00000001, 4'd0,  16'd100,  2'd1, 8'd0,   16'd3,   8'd1,   4'd3},
        {32'h00000011, 4'd0,  16'd100,  2'd0, 8'd1,   16'd4,   8'd2,   4'd3},
        {32'h00002121, 4'd0,  16'd100,  2'd0, 8'd3,   16'd6,   8'd4,   4'd3},
        {32'h00001222, 4'd0,  16'd100,  2'd1, 8'd3,   16'd6,   8'd4,   4'd3},
        {32'h11111111, 4'd0,  16'd100,  2'd0, 8'd7,   16'd10,  8'd8,   4'd3},
        {32'h00000000, 4'd2,  16'd5,    2'd2, 8'd1,   16'd6,   8'd0,   4'd0},
        {32'h00000011, 4'd0,  16'd3,    2'd0, 8'd1,   16'd4,   8'd2,   4'd3},
        {32'h00000011, 4'd0,  16'd2,    2'd2, 8'd2,   16'd3,   8'd2,   4'd0},
        {32'h00000000, 4'd0,  16'd0,    2'd2, 8'd0,   16'd1,   8'd0,   4'd0},
        {32'h00000000, 4'd4,  16'd1000, 2'd3, 8'd255, 16'd256, 8'd255, 4'd0},
        {32'h00000001, 4'd14, 16'd100,  2'd0, 8'd0,   16'd1,   8'd0,   4'd1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put_rule(input logic [3:0] st, input logic [3:0] sy,
                            input logic [3:0] nx, input logic [3:0] wr, input logic rt);
        @(negedge clk);
        rule_we = 1'b1; rule_addr = {st, sy}; rule_data = {nx, wr, rt};
        @(negedge clk);
        rule_we = 1'b0;
    endtask

    task automatic put_cell(input logic [7:0] a, input logic [3:0] s);
        @(negedge clk);
        tape_we = 1'b1; tape_waddr = a; tape_wdata = s;
        @(negedge clk);
        tape_we = 1'b0;
    endtask

    function automatic int outcome();
        return accepted ? 0 : rejected ? 1 : timed_out ? 2 : overflow ? 3 : 9;
    endfunction

    task automatic launch(input logic [3:0] st, input logic [15:0] lim);
        @(negedge clk);
        start_state = st; step_limit = lim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        int bcount;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 busy/done", {busy, done}, 0);
        check(!(accepted || rejected || timed_out || overflow), "R1 flags",
              {accepted, rejected, timed_out, overflow}, 0);
        check(head_pos == 8'd0, "R1 head", head_pos, 0);
        for (int a = 0; a < 256; a += 51) begin
            tape_raddr = 8'(a);
            #1;
            check(tape_rdata == 4'd0, "R1 tape blank", tape_rdata, 0);
        end

        // program: parity of symbol 1, plus ping-pong loop and right runner
        put_rule(4'd0, 4'd1, 4'd1,  4'd1, 1'b1);
        put_rule(4'd0, 4'd2, 4'd0,  4'd2, 1'b1);
        put_rule(4'd1, 4'd1, 4'd0,  4'd1, 1'b1);
        put_rule(4'd1, 4'd2, 4'd1,  4'd2, 1'b1);
        put_rule(4'd0, 4'd0, 4'd14, 4'd3, 1'b0);
        put_rule(4'd1, 4'd0, 4'd15, 4'd3, 1'b0);
        put_rule(4'd2, 4'd0, 4'd3,  4'd0, 1'b1);
        put_rule(4'd3, 4'd0, 4'd2,  4'd0, 1'b0);
        put_rule(4'd4, 4'd0, 4'd4,  4'd0, 1'b1);

        for (int v = 0; v < NV; v++) begin
            logic [89:0] t;
            t = VEC[v];
            for (int c = 0; c < 16; c++) put_cell(8'(c), 4'd0);
            for (int c = 0; c < 8; c++) put_cell(8'(c), t[58 + 4*c +: 4]);
            launch(t[57:54], t[53:38]);
            bcount = 0;
            while (busy && bcount < 5000) begin
                // R9 flags hidden while running
                if (accepted || rejected || timed_out || overflow) begin
                    check(0, "R9 flags while busy", 1, 0);
                end
                bcount++;
                @(negedge clk);
            end
            // busy counted from the first negedge after the start edge
            check(bcount == int'(t[27:12]), "R5/R8 busy cycles", bcount, int'(t[27:12]));
            check(done, "R4/R6/R8 done", done, 1);
            check(outcome() == int'(t[37:36]), "R4/R6/R8 outcome", outcome(), int'(t[37:36]));
            check(head_pos == t[35:28], "R3/R7/R8 head", head_pos, int'(t[35:28]));
            tape_raddr = t[11:4];
            #1;
            check(tape_rdata == t[3:0], "R3 tape write", tape_rdata, int'(t[3:0]));
            @(negedge clk);
            check(done && outcome() == int'(t[37:36]), "R10 hold", outcome(), int'(t[37:36]));
        end

        // R11: writes and start ignored during a run
        for (int c = 0; c < 16; c++) put_cell(8'(c), 4'd0);
        launch(4'd2, 16'd50);
        bcount = 1;
        repeat (4) begin @(negedge clk); bcount++; end
        tape_we = 1'b1; tape_waddr = 8'd10; tape_wdata = 4'd7;
        rule_we = 1'b1; rule_addr = 8'h00; rule_data = {4'd15, 4'd3, 1'b0};
        start = 1'b1; start_state = 4'd0;
        @(negedge clk); bcount++;
        tape_we = 1'b0; rule_we = 1'b0; start = 1'b0;
        while (busy && bcount < 5000) begin @(negedge clk); bcount++; end
        bcount--;
        check(bcount == 51, "R11 start ignored busy cycles", bcount, 51);
        check(timed_out, "R11 timeout outcome", outcome(), 2);
        tape_raddr = 8'd10;
        #1;
        check(tape_rdata == 4'd0, "R11 tape write ignored", tape_rdata, 0);
        // rerun empty input: rule (0,0) must still lead to accept
        launch(4'd0, 16'd100);
        while (busy) @(negedge clk);
        check(accepted, "R11 rule write ignored", outcome(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule